// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles and returns an N-bit quotient and an N-bit remainder. It uses a single subtractor and one combined shift register. The partial remainder grows in the upper part of that register while quotient bits enter at the bottom. Each cycle the block tries one subtraction. If the difference would be negative, the old partial remainder is kept, which is the restoring case.

A caller presents the operands with a one-cycle `start` while `busy` is low, then waits for the one-cycle `done` pulse. The results stay on the outputs until the next result replaces them. A mode input selects unsigned or two's-complement division. In signed mode the block divides the magnitudes and fixes the signs at the end. A zero divisor is detected when the operation is accepted and is answered at once, without running the loop.

Top module: `restoring_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `busy`, `done` and `div_by_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A `start` taken while idle with a nonzero divisor raises `busy` from the next cycle. `done` is high, with `busy` low, exactly in the cycle after the (N+1)-th edge following the accepting edge, and only for that one cycle.
- R3: With `signed_mode` = 0, `quotient` is floor(dividend / divisor) and `remainder` is dividend − quotient × divisor, both unsigned.
- R4: With `signed_mode` = 1, operands are two's complement. The quotient truncates toward zero and is negative when exactly one operand is negative. The remainder has the dividend's sign (−7 ÷ 2 gives −3 rem −1; 7 ÷ −2 gives −3 rem 1).
- R5: In signed mode, the most negative value divided by −1 returns the most negative value as `quotient` and 0 as `remainder`.
- R6: A zero divisor sets `div_by_zero`, returns all ones as `quotient` and the unmodified dividend as `remainder`, and pulses `done` in the cycle after the accepting edge with `busy` staying low. The next result with a nonzero divisor clears `div_by_zero`.
- R7: A `start` while `busy` is high is ignored. The running result is unchanged, its timing is unchanged, and no extra operation follows it.
- R8: `quotient`, `remainder` and `div_by_zero` change only in a cycle where `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a division; sampled only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W | Dividend, captured with `start` |
| divisor | input | W | Divisor, captured with `start` |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | W | Quotient of the last operation |
| remainder | output | W | Remainder of the last operation |
| div_by_zero | output | 1 | Last operation had a zero divisor |

## Verification
With a nonzero divisor, `busy` is due one cycle after the accepting edge. The results and `done` are due N+1 edges later, and `done` is low again one edge after that. With a zero divisor, everything is due one edge after acceptance. The bench drives each request on a falling edge and counts falling edges from there. It samples at the exact cycle each output is due, and also one cycle before and one cycle after the result. This catches both early and late results and any stretched pulse. Operand inputs are scrambled after capture and during the hold window, so a result that tracks the live inputs is caught.

// File: rtl/rdiv_pkg.sv
// Shared types for the restoring divider.
// Assumes: nothing beyond IEEE 1800-2017.
package rdiv_pkg;

    // Control states of the divider sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } rdiv_state_e;

endpackage

// File: rtl/rdiv_magnitude.sv
// Converts an operand to an unsigned magnitude and reports whether it was negative.
// Assumes: in unsigned mode the value is passed through untouched; the most
// negative value maps to its own bit pattern, which is correct as an unsigned magnitude.
module rdiv_magnitude #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic         signed_mode,
    output logic [W-1:0] mag,
    output logic         neg
);

    // Sign detect and conditional two's complement negation.
    always_comb begin
        neg = signed_mode & value[W-1];
        mag = neg ? (~value + W'(1)) : value;
    end

endmodule

// File: rtl/rdiv_step.sv
// One restoring division step on the combined register {hi, lo}.
// hi is W+1 bits wide (one guard bit), lo is W bits wide.
// Assumes: hi < 2*dvs on entry, so a successful difference fits in W bits.
module rdiv_step #(
    parameter int W = 8
) (
    input  logic [2*W:0] acc,
    input  logic [W-1:0] dvs,
    output logic [2*W:0] acc_next
);

    logic [W:0]   hi;
    logic [W+1:0] trial;

    // Trial subtraction of the divisor from the high part, then shift in the quotient bit.
    always_comb begin
        hi    = acc[2*W:W];
        trial = {1'b0, hi} - {2'b00, dvs};
        if (!trial[W+1]) begin
            acc_next = {trial[W-1:0], acc[W-1:0], 1'b1};
        end else begin
            acc_next = {acc[2*W-1:0], 1'b0};
        end
    end

endmodule

// File: rtl/restoring_div.sv
// Multi-cycle restoring divider, W-bit quotient and remainder.
// One subtractor and one (2W+1)-bit register: remainder in the high part,
// quotient entering at the low end. Signed mode divides magnitudes and fixes
// the signs afterwards. Assumes start is only honoured while busy is low.
module restoring_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    import rdiv_pkg::*;

    localparam int          CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rdiv_state_e   state_q;
    logic [2*W:0]  acc_q;
    logic [2*W:0]  acc_next;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          negq_q;
    logic          negr_q;

    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic          neg_a;
    logic          neg_b;
    logic [W-1:0]  quot_mag;
    logic [W-1:0]  rem_mag;

    rdiv_magnitude #(.W(W)) i_mag_a (
        .value(dividend), .signed_mode(signed_mode), .mag(mag_a), .neg(neg_a)
    );

    rdiv_magnitude #(.W(W)) i_mag_b (
        .value(divisor), .signed_mode(signed_mode), .mag(mag_b), .neg(neg_b)
    );

    rdiv_step #(.W(W)) i_step (
        .acc(acc_q), .dvs(dvs_q), .acc_next(acc_next)
    );

    // Final correction: the high part was shifted once too often.
    always_comb begin
        quot_mag = acc_q[W-1:0];
        rem_mag  = acc_q[2*W:W+1];
    end

    // Busy covers the iteration and the sign-fix cycle.
    assign busy = (state_q != ST_IDLE);

    // Sequencer, datapath register and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            acc_q       <= '0;
            dvs_q       <= '0;
            cnt_q       <= '0;
            negq_q      <= 1'b0;
            negr_q      <= 1'b0;
            done        <= 1'b0;
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            done        <= 1'b1;
                            div_by_zero <= 1'b1;
                            quotient    <= '1;
                            remainder   <= dividend;
                        end else begin
                            acc_q   <= {{W{1'b0}}, mag_a, 1'b0};
                            dvs_q   <= mag_b;
                            cnt_q   <= '0;
                            negq_q  <= neg_a ^ neg_b;
                            negr_q  <= neg_a;
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_next;
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    quotient    <= negq_q ? (~quot_mag + W'(1)) : quot_mag;
                    remainder   <= negr_q ? (~rem_mag + W'(1)) : rem_mag;
                    div_by_zero <= 1'b0;
                    done        <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < CW'(W))); // R2
    AST_HOLD_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvs_q)); // R7
    AST_DZ_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1)); // R6
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero && !negq_q && !negr_q) |-> (remainder < dvs_q)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quotient) |-> done); // R8

endmodule

// File: tb/test_restoring_div.sv
`timescale 1ns/1ps
module test_restoring_div;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    restoring_div #(.W(W)) i_restoring_div (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model: unsigned or truncating signed division.
    function automatic void ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic sgn, output logic [W-1:0] q,
                                    output logic [W-1:0] r);
        int sa, sb, sq, sr;
        if (b == '0) begin
            q = '1; r = a;
        end else if (sgn) begin
            sa = $signed(a); sb = $signed(b);
            sq = sa / sb; sr = sa % sb;
            q = sq[W-1:0]; r = sr[W-1:0];
        end else begin
            q = a / b; r = a % b;
        end
    endfunction

    // One full operation; optionally pokes start while busy (R7).
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic sgn, input logic poke, input string req);
        logic [W-1:0] eq, er;
        ref_div(a, b, sgn, eq, er);
        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; signed_mode = sgn;
        @(negedge clk);
        start = 1'b0; dividend = W'($urandom); divisor = W'($urandom);
        signed_mode = 1'($urandom);
        if (b == '0) begin
            chk("R6", "dz done", 32'(done), 32'd1);
            chk("R6", "dz busy", 32'(busy), 32'd0);
            chk("R6", "dz flag", 32'(div_by_zero), 32'd1);
            chk("R6", "dz quotient", 32'(quotient), 32'(eq));
            chk("R6", "dz remainder", 32'(remainder), 32'(er));
            @(negedge clk);
            chk("R2", "dz done width", 32'(done), 32'd0);
            return;
        end
        chk("R2", "busy after start", 32'(busy), 32'd1);
        chk("R2", "done early", 32'(done), 32'd0);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            if (poke && i == 0) begin
                start = 1'b1; divisor = W'($urandom) | W'(1);
                dividend = W'($urandom);
            end
            if (i == 1) start = 1'b0;
        end
        chk("R2", "done one cycle early", 32'(done), 32'd0);
        chk("R2", "busy before done", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R2", "done due", 32'(done), 32'd1);
        chk("R2", "busy at done", 32'(busy), 32'd0);
        chk(req, "quotient", 32'(quotient), 32'(eq));
        chk(req, "remainder", 32'(remainder), 32'(er));
        chk("R6", "dz clear", 32'(div_by_zero), 32'd0);
        @(negedge clk);
        chk("R2", "done width", 32'(done), 32'd0);
        if (poke) chk("R7", "no queued op", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] hq, hr;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        chk("R1", "busy reset", 32'(busy), 32'd0);
        chk("R1", "done reset", 32'(done), 32'd0);
        chk("R1", "quotient reset", 32'(quotient), 32'd0);
        chk("R1", "remainder reset", 32'(remainder), 32'd0);
        chk("R1", "dz reset", 32'(div_by_zero), 32'd0);
        rst_n = 1'b1;

        run_op(8'd7, 8'd2, 1'b0, 1'b0, "R3");
        run_op(8'd255, 8'd1, 1'b0, 1'b0, "R3");
        run_op(8'd1, 8'd255, 1'b0, 1'b0, "R3");
        run_op(8'd255, 8'd255, 1'b0, 1'b0, "R3");
        run_op(8'd0, 8'd9, 1'b0, 1'b0, "R3");
        run_op(8'hF9, 8'd2, 1'b1, 1'b0, "R4");
        run_op(8'd7, 8'hFE, 1'b1, 1'b0, "R4");
        run_op(8'hF9, 8'hFE, 1'b1, 1'b0, "R4");
        run_op(8'h80, 8'h7F, 1'b1, 1'b0, "R4");
        run_op(8'h80, 8'hFF, 1'b1, 1'b0, "R5");
        run_op(8'h5A, 8'd0, 1'b0, 1'b0, "R6");
        run_op(8'h93, 8'd0, 1'b1, 1'b0, "R6");
        run_op(8'd100, 8'd7, 1'b0, 1'b1, "R7");
        run_op(8'h9C, 8'd7, 1'b1, 1'b1, "R7");

        hq = quotient; hr = remainder;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            dividend = W'($urandom); divisor = W'($urandom);
            chk("R8", "quotient hold", 32'(quotient), 32'(hq));
            chk("R8", "remainder hold", 32'(remainder), 32'(hr));
        end

        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] a, b;
            logic s;
            a = W'($urandom);
            b = W'($urandom);
            s = 1'($urandom);
            case ($urandom % 8)
                0: b = '0;
                1: b = W'($urandom % 4);
                2: begin a = 8'h80; b = 8'hFF; s = 1'b1; end
                default: ;
            endcase
            run_op(a, b, s, ($urandom % 10) == 0, s ? "R4" : "R3");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule